// File: doc/BRIEF.md
# Fault-Injectable Circuit-Switched Channel

The block carries one bit from one of two senders (A, B) over a single shared channel to one of two receivers (C, D). The sending side is a 2x2 crossbar whose outputs feed a 2:1 multiplexer that drives the channel. The receiving side is a 1:2 demultiplexer whose outputs feed a second 2x2 crossbar. A four-bit control word picks the path. What decides the routing is whether the two controls of a stage are equal, not what their values are.

Every control line passes through a stuck-at injector. The path actually taken (from the effective word) and the path intended (from the applied word) are both reported as two-bit codes, and a flag is raised when they differ. This lets a test harness see how single, paired or global stuck faults corrupt the routing. Latency is modelled as a chain of clock-zone registers, one per clock edge. The control words travel with the data bit, so each report lines up with the bit it describes.

Top module: `cs_channel`

## Requirements
- R1: The channel carries `snd_a_i` when `ctrl_i[3]` (sender crossbar control) equals `ctrl_i[2]` (sender multiplexer control), using effective values, and carries `snd_b_i` otherwise.
- R2: The channel bit is delivered on `rcv_c_o` when effective `ctrl_i[1]` (receiver demultiplexer control) equals effective `ctrl_i[0]` (receiver crossbar control), and on `rcv_d_o` otherwise.
- R3: The receiver output that is not selected is 0, so `rcv_c_o` and `rcv_d_o` are never both 1.
- R4: The effective value of control bit i is `force_val_i[i]` when `force_en_i[i]` is 1, and `ctrl_i[i]` otherwise.
- R5: `path_eff_o` encodes the effective path and `path_ref_o` the applied path. Bit 1 is the source (0 = A, 1 = B) and bit 0 is the destination (0 = C, 1 = D).
- R6: `path_err_o` is 1 exactly when `path_eff_o` differs from `path_ref_o`.
- R7: With default parameters, inputs sampled at one clock edge appear on all outputs after the 8th edge from it (4 sender zones plus 4 receiver zones). The report is aligned with the delivered bit.
- R8: A synchronous reset clears every stage, so all outputs read 0 on the cycle after a reset edge, and also after a reset applied mid-stream.
- R9: When all four lines are forced to the same value, the path is always A to C, and the error flag is set unless the applied word is 0000, 0011, 1100 or 1111.
- R10: Forcing both controls of one stage to a common value leaves that stage's routing unchanged when its applied controls were equal, and corrupts it when they were unequal.
- R11: A new independent word and data pair may be accepted on every clock. Each result depends only on its own inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one clock-zone tick per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| snd_a_i | input | 1 | Sender A data bit |
| snd_b_i | input | 1 | Sender B data bit |
| ctrl_i | input | 4 | Applied control word, bit 3 first |
| force_en_i | input | 4 | Per-line stuck-at enable |
| force_val_i | input | 4 | Per-line stuck-at value |
| rcv_c_o | output | 1 | Receiver C data |
| rcv_d_o | output | 1 | Receiver D data |
| path_eff_o | output | 2 | Path actually taken |
| path_ref_o | output | 2 | Path intended by applied word |
| path_err_o | output | 1 | Actual and intended paths differ |

## Verification
The routing assertions rely on every input being a defined 0 or 1, held steady across the rising edge. The stimulus always changes inputs on the falling edge and never leaves them unknown. The pipeline-advance assertion assumes reset is either held for whole cycles or released cleanly, which the reset sequences respect. A behavioural queue model predicts every output from the applied inputs. Directed phases cover exhaustive fault-free words, single-line faults, global forcing, stage-pair forcing and a long random stream.

// File: rtl/cs_chan_pkg.sv
package cs_chan_pkg;

    localparam int CTRL_W     = 4;
    localparam int IX_TX_XBAR = 3;
    localparam int IX_TX_MUX  = 2;
    localparam int IX_RX_DMX  = 1;
    localparam int IX_RX_XBAR = 0;

    typedef logic [CTRL_W-1:0] ctrl_word_t;

    typedef struct packed {
        logic       chan;
        ctrl_word_t eff;
        ctrl_word_t want;
    } tx_beat_t;

    typedef struct packed {
        logic       out_c;
        logic       out_d;
        ctrl_word_t eff;
        ctrl_word_t want;
    } rx_beat_t;

    function automatic logic [1:0] path_code(input ctrl_word_t w);
        logic src;
        logic dst;
        src = w[IX_TX_XBAR] ^ w[IX_TX_MUX];
        dst = w[IX_RX_DMX] ^ w[IX_RX_XBAR];
        return {src, dst};
    endfunction

endpackage

// File: rtl/cs_xbar.sv
module cs_xbar #(
    parameter int WIDTH = 1
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             sel,
    output logic [WIDTH-1:0] to_c,
    output logic [WIDTH-1:0] to_d
);

    always_comb begin
        to_c = sel ? in_b : in_a;
        to_d = sel ? in_a : in_b;
    end

endmodule

// File: rtl/cs_zone_pipe.sv
module cs_zone_pipe #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stage;
    } pipe_state_t;

    pipe_state_t st_d;
    pipe_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.stage = '0;
        end else begin
            st_d.stage[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.stage[i] = st_q.stage[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.stage[LAST];

    generate
        if (DEPTH > 1) begin : g_adv_chk
            AST_PIPE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> st_q.stage[LAST] == $past(st_q.stage[LAST-1])); // R7
        end
    endgenerate

endmodule

// File: rtl/cs_fault_inject.sv
module cs_fault_inject
    import cs_chan_pkg::*;
(
    input  ctrl_word_t ctrl_in,
    input  ctrl_word_t force_en,
    input  ctrl_word_t force_val,
    output ctrl_word_t ctrl_eff
);

    genvar gi;
    generate
        for (gi = 0; gi < CTRL_W; gi++) begin : g_line
            assign ctrl_eff[gi] = force_en[gi] ? force_val[gi] : ctrl_in[gi];
        end
    endgenerate

endmodule

// File: rtl/cs_tx_stage.sv
module cs_tx_stage
    import cs_chan_pkg::*;
#(
    parameter int ZONES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       snd_a,
    input  logic       snd_b,
    input  ctrl_word_t eff,
    input  ctrl_word_t want,
    output tx_beat_t   beat_out
);

    localparam int BEAT_W = $bits(tx_beat_t);

    logic     xb_c;
    logic     xb_d;
    tx_beat_t beat_d;
    logic [BEAT_W-1:0] pipe_out;

    cs_xbar #(.WIDTH(1)) u_xbar (
        .in_a (snd_a),
        .in_b (snd_b),
        .sel  (eff[IX_TX_XBAR]),
        .to_c (xb_c),
        .to_d (xb_d)
    );

    always_comb begin
        beat_d      = '0;
        beat_d.chan = eff[IX_TX_MUX] ? xb_d : xb_c;
        beat_d.eff  = eff;
        beat_d.want = want;
        if (eff[IX_TX_XBAR] == eff[IX_TX_MUX]) begin
            AST_TX_PICK_A: assert (beat_d.chan == snd_a); // R1
        end else begin
            AST_TX_PICK_B: assert (beat_d.chan == snd_b); // R1
        end
    end

    cs_zone_pipe #(.WIDTH(BEAT_W), .DEPTH(ZONES)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .din  (beat_d),
        .dout (pipe_out)
    );

    assign beat_out = tx_beat_t'(pipe_out);

endmodule

// File: rtl/cs_rx_stage.sv
module cs_rx_stage
    import cs_chan_pkg::*;
#(
    parameter int ZONES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  tx_beat_t beat_in,
    output rx_beat_t beat_out
);

    localparam int BEAT_W = $bits(rx_beat_t);

    logic     dmx_lo;
    logic     dmx_hi;
    logic     xb_c;
    logic     xb_d;
    rx_beat_t beat_d;
    logic [BEAT_W-1:0] pipe_out;

    always_comb begin
        dmx_lo = beat_in.eff[IX_RX_DMX] ? 1'b0 : beat_in.chan;
        dmx_hi = beat_in.eff[IX_RX_DMX] ? beat_in.chan : 1'b0;
    end

    cs_xbar #(.WIDTH(1)) u_xbar (
        .in_a (dmx_lo),
        .in_b (dmx_hi),
        .sel  (beat_in.eff[IX_RX_XBAR]),
        .to_c (xb_c),
        .to_d (xb_d)
    );

    always_comb begin
        beat_d       = '0;
        beat_d.out_c = xb_c;
        beat_d.out_d = xb_d;
        beat_d.eff   = beat_in.eff;
        beat_d.want  = beat_in.want;
        AST_RX_ONE_ACTIVE: assert (!(xb_c && xb_d)); // R3
        if (beat_in.eff[IX_RX_DMX] == beat_in.eff[IX_RX_XBAR]) begin
            AST_RX_TO_C: assert (xb_c == beat_in.chan && !xb_d); // R2
        end else begin
            AST_RX_TO_D: assert (xb_d == beat_in.chan && !xb_c); // R2
        end
    end

    cs_zone_pipe #(.WIDTH(BEAT_W), .DEPTH(ZONES)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .din  (beat_d),
        .dout (pipe_out)
    );

    assign beat_out = rx_beat_t'(pipe_out);

endmodule

// File: rtl/cs_channel.sv
module cs_channel
    import cs_chan_pkg::*;
#(
    parameter int TX_ZONES = 4,
    parameter int RX_ZONES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       snd_a_i,
    input  logic       snd_b_i,
    input  logic [3:0] ctrl_i,
    input  logic [3:0] force_en_i,
    input  logic [3:0] force_val_i,
    output logic       rcv_c_o,
    output logic       rcv_d_o,
    output logic [1:0] path_eff_o,
    output logic [1:0] path_ref_o,
    output logic       path_err_o
);

    ctrl_word_t eff_word;
    tx_beat_t   tx_beat;
    rx_beat_t   rx_beat;

    cs_fault_inject u_inject (
        .ctrl_in   (ctrl_i),
        .force_en  (force_en_i),
        .force_val (force_val_i),
        .ctrl_eff  (eff_word)
    );

    cs_tx_stage #(.ZONES(TX_ZONES)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .snd_a    (snd_a_i),
        .snd_b    (snd_b_i),
        .eff      (eff_word),
        .want     (ctrl_i),
        .beat_out (tx_beat)
    );

    cs_rx_stage #(.ZONES(RX_ZONES)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .beat_in  (tx_beat),
        .beat_out (rx_beat)
    );

    always_comb begin
        rcv_c_o    = rx_beat.out_c;
        rcv_d_o    = rx_beat.out_d;
        path_eff_o = path_code(rx_beat.eff);
        path_ref_o = path_code(rx_beat.want);
        path_err_o = (path_eff_o != path_ref_o);
    end

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rcv_c_o && rcv_d_o)); // R3

endmodule

// File: tb/cs_channel_tb_top.sv
module cs_channel_tb_top;

    localparam int LAT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a = 1'b0;
    logic       b = 1'b0;
    logic [3:0] ctrl = '0;
    logic [3:0] fen = '0;
    logic [3:0] fval = '0;
    logic       out_c;
    logic       out_d;
    logic [1:0] p_eff;
    logic [1:0] p_ref;
    logic       p_err;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string tag = "R8";
    int    exp_q[$];

    always #2 clk = ~clk;

    cs_channel dut_i (
        .clk (clk), .rst (rst), .snd_a_i (a), .snd_b_i (b), .ctrl_i (ctrl),
        .force_en_i (fen), .force_val_i (fval), .rcv_c_o (out_c), .rcv_d_o (out_d),
        .path_eff_o (p_eff), .path_ref_o (p_ref), .path_err_o (p_err)
    );

    // Behavioural prediction: {c, d, eff_code, ref_code, err}
    function automatic int predict(logic da, logic db, logic [3:0] w,
                                   logic [3:0] en, logic [3:0] v);
        logic [3:0] e;
        int  src, dst, rsrc, rdst;
        logic bitv, c, d;
        for (int i = 0; i < 4; i++) e[i] = en[i] ? v[i] : w[i];
        src  = (e[3] != e[2]) ? 1 : 0;
        dst  = (e[1] != e[0]) ? 1 : 0;
        rsrc = (w[3] != w[2]) ? 1 : 0;
        rdst = (w[1] != w[0]) ? 1 : 0;
        bitv = (src == 1) ? db : da;
        c = (dst == 0) ? bitv : 1'b0;
        d = (dst == 1) ? bitv : 1'b0;
        return (int'(c) << 6) | (int'(d) << 5) | (src << 4) | (dst << 3)
             | (rsrc << 2) | (rdst << 1) | (((src != rsrc) || (dst != rdst)) ? 1 : 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            for (int i = 0; i < LAT; i++) exp_q.push_back(0);
        end else begin
            exp_q.push_back(predict(a, b, ctrl, fen, fval));
            void'(exp_q.pop_front());
        end
    end

    task automatic check_outputs();
        int e;
        e = (exp_q.size() > 0) ? exp_q[0] : 0;
        checks++;
        if ({out_c, out_d} != e[6:5]) begin
            failures++;
            $display("FAIL %s R1 R2 R3 R7 data cd got %b%b exp %b", tag, out_c, out_d, e[6:5]);
        end
        checks++;
        if ({p_eff, p_ref} != e[4:1]) begin
            failures++;
            $display("FAIL %s R4 R5 path eff/ref got %b/%b exp %b/%b", tag, p_eff, p_ref, e[4:3], e[2:1]);
        end
        checks++;
        if (p_err != e[0]) begin
            failures++;
            $display("FAIL %s R6 err got %b exp %b", tag, p_err, e[0]);
        end
    endtask

    task automatic step(logic na, logic nb, logic [3:0] w, logic [3:0] en, logic [3:0] v);
        @(negedge clk);
        check_outputs();
        a = na; b = nb; ctrl = w; fen = en; fval = v;
    endtask

    task automatic check_zero();
        checks++;
        if ({out_c, out_d, p_eff, p_ref, p_err} != 7'd0) begin
            failures++;
            $display("FAIL R8 reset outputs got %b exp 0000000",
                     {out_c, out_d, p_eff, p_ref, p_err});
        end
    endtask

    task automatic flush();
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 1'b0, 4'b0, 4'b0, 4'b0);
    endtask

    initial begin
        // R8: reset state
        a = 1'b1; b = 1'b1; ctrl = 4'b1010;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_zero();
        rst = 1'b0;

        // R1 R2 R3 R5 R7: every word with every data pair, no faults
        tag = "R1 R2";
        for (int w = 0; w < 16; w++)
            for (int d = 0; d < 4; d++)
                step(d[1], d[0], w[3:0], 4'b0, 4'b0);
        flush();

        // R4: single-line faults
        tag = "R4";
        for (int ln = 0; ln < 4; ln++)
            for (int w = 0; w < 16; w++)
                step(w[0], ~w[1], w[3:0], 4'(1 << ln), 4'(w[2] ? 15 : 0));
        flush();

        // R9: all four lines forced to 0 and to 1
        tag = "R9";
        for (int v = 0; v < 2; v++)
            for (int w = 0; w < 16; w++)
                step(1'b1, 1'b0, w[3:0], 4'b1111, v[0] ? 4'b1111 : 4'b0000);
        flush();

        // R10: both controls of one stage forced to a common value
        tag = "R10";
        for (int st = 0; st < 2; st++)
            for (int v = 0; v < 2; v++)
                for (int w = 0; w < 16; w++)
                    step(w[1], w[3], w[3:0], st[0] ? 4'b0011 : 4'b1100,
                         v[0] ? 4'b1111 : 4'b0000);
        flush();

        // R11: back-to-back random stream with random faults
        tag = "R11";
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            step(r[0], r[1], r[5:2], (r[15:14] == 2'b00) ? r[9:6] : 4'b0, r[13:10]);
        end

        // R8: mid-stream reset
        @(negedge clk);
        check_outputs();
        rst = 1'b1;
        @(negedge clk);
        check_zero();
        rst = 1'b0;
        tag = "R8";
        flush();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule